// File: doc/BRIEF.md
# Host-to-Firmware Command Mailbox

This block is a register-mapped mailbox between a host processor and an embedded power-management controller. The host writes a command word, two pointer words and up to four payload words through a plain 32-bit register port, and reads back a status word and up to four response words. The firmware side sees a one-cycle doorbell whenever a command is accepted. It can read the command word, the pointers and the payload words, fill the response words, and post a completion strobe that carries an error flag and an 8-bit error code.

A three-state controller tracks each command. In `ST_IDLE` no command is outstanding. A host command write in `ST_IDLE` moves it to `ST_RING`, the single cycle in which the doorbell is high. If the firmware completes in that cycle, `ST_RING` goes to `ST_IDLE`; otherwise it goes to `ST_WAIT`. `ST_WAIT` stays put until completion and then goes to `ST_IDLE`. Busy is high in `ST_RING` and `ST_WAIT`. When a command asked for an interrupt (command bit 8), completion raises a level interrupt toward the host. The interrupt stays high until the host writes the status word with bit 2 set.

Top module: `hostfw_mailbox`

## Requirements
- R1: After reset every register and buffer word reads zero, busy is 0, the doorbell is low and the host interrupt is low.
- R2: A host write to offset 0x00 while idle stores the command word, reads back busy (status bit 0) = 1 right after that edge, and drives the doorbell high for exactly the next cycle.
- R3: A host write to offset 0x00 while busy leaves the stored command unchanged and produces no doorbell. It sets a sticky overrun flag in status bit 3, and only a status write with bit 3 set clears that flag.
- R4: A completion strobe while busy clears busy on its edge and loads the error flag (status bit 1) from the firmware error input. It loads the error code into status bits 23:16 when the error flag is set, and loads zero there otherwise. Accepting a new command clears both fields.
- R5: At completion, the interrupt flag (status bit 2) and the host interrupt output are set exactly when bit 8 of the accepted command is 1. Both hold until a status write with bit 2 set.
- R6: A completion strobe while idle changes nothing.
- R7: Host writes to offsets 0x80 + 4k (k = 0..3) fill payload word k. The host reads that word back at the same offset, and the firmware reads it by word index.
- R8: Firmware writes to response word k appear to host reads at offset 0x90 + 4k.
- R9: The source pointer (0x08) and destination pointer (0x0C) are host-writable, readable by the host, and presented to the firmware.
- R10: Reads from undefined offsets return zero, and writes to them change no register.
- R11: The firmware sees the command code (bits 7:0), the subcommand (bits 15:12) and the payload length in whole words. That length is the byte length in bits 23:16, clamped to 16 and rounded up to a multiple of 4.

Error code meanings: 0 none, 1 unsupported, 2 not serviced, 3 cannot service, 4 invalid, 5 failed, 6 security rejection, 7 unsigned image.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| host_wr | input | 1 | Host write strobe |
| host_addr | input | 8 | Host byte offset |
| host_wdata | input | 32 | Host write data |
| host_rdata | output | 32 | Host read data for host_addr (combinational) |
| host_irq | output | 1 | Completion interrupt, level |
| fw_doorbell | output | 1 | One-cycle pulse per accepted command |
| fw_cmd | output | 32 | Stored command word |
| fw_code | output | 8 | Command code field |
| fw_sub | output | 4 | Subcommand field |
| fw_len_words | output | 3 | Payload length in words (0..4) |
| fw_sptr | output | 32 | Source pointer |
| fw_dptr | output | 32 | Destination pointer |
| fw_wbuf_idx | input | 2 | Payload word select |
| fw_wbuf_data | output | 32 | Selected payload word |
| fw_rbuf_we | input | 1 | Response word write strobe |
| fw_rbuf_idx | input | 2 | Response word select |
| fw_rbuf_wdata | input | 32 | Response word data |
| fw_done | input | 1 | Completion strobe |
| fw_err | input | 1 | Error flag posted with completion |
| fw_err_code | input | 8 | Error code posted with completion |

## Verification
Every register write, the command acceptance and the completion take effect on the clock edge of the strobe. Host reads are combinational, so status, buffer and pointer values are due one edge after their stimulus. The doorbell is due in the cycle after the command edge and must be gone one edge later. The bench drives inputs on the falling edge and samples 1 ns after the rising edge that commits them. A result is never read in the stimulus cycle. The interrupt is sampled again one cycle later to prove it holds before the acknowledge.

// File: rtl/mbx_pkg.sv
package mbx_pkg;
    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_RING = 2'd1,
        ST_WAIT = 2'd2
    } mbx_state_e;

    localparam logic [7:0] OFS_CMD  = 8'h00;
    localparam logic [7:0] OFS_STS  = 8'h04;
    localparam logic [7:0] OFS_SPTR = 8'h08;
    localparam logic [7:0] OFS_DPTR = 8'h0C;
    localparam logic [7:0] OFS_WBUF = 8'h80;
    localparam logic [7:0] OFS_RBUF = 8'h90;

    localparam int STS_BUSY_BIT = 0;
    localparam int STS_ERR_BIT  = 1;
    localparam int STS_IRQ_BIT  = 2;
    localparam int STS_OVR_BIT  = 3;
    localparam int CMD_IRQ_BIT  = 8;
endpackage

// File: rtl/mbx_ctrl_fsm.sv
module mbx_ctrl_fsm
    import mbx_pkg::*;
#(
    parameter int CODE_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cmd_wr,
    input  logic              ack_irq,
    input  logic              ack_ovr,
    input  logic              irq_req,
    input  logic              fw_done,
    input  logic              fw_err,
    input  logic [CODE_W-1:0] fw_err_code,
    output logic              cmd_accept,
    output logic              doorbell,
    output logic              busy,
    output logic              err_flag,
    output logic [CODE_W-1:0] err_code,
    output logic              irq_flag,
    output logic              ovr_flag
);
    mbx_state_e state_q, state_d;
    logic       complete;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: if (cmd_wr)  state_d = ST_RING;
            ST_RING: state_d = fw_done ? ST_IDLE : ST_WAIT;
            ST_WAIT: if (fw_done) state_d = ST_IDLE;
            default: state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        busy       = (state_q != ST_IDLE);
        doorbell   = (state_q == ST_RING);
        cmd_accept = cmd_wr && (state_q == ST_IDLE);
        complete   = fw_done && busy;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            err_flag <= 1'b0;
            err_code <= '0;
            irq_flag <= 1'b0;
            ovr_flag <= 1'b0;
        end else begin
            if (cmd_accept) begin
                err_flag <= 1'b0;
                err_code <= '0;
            end else if (complete) begin
                err_flag <= fw_err;
                err_code <= fw_err ? fw_err_code : '0;
            end
            if (complete && irq_req) irq_flag <= 1'b1;
            else if (ack_irq)        irq_flag <= 1'b0;
            if (cmd_wr && busy)      ovr_flag <= 1'b1;
            else if (ack_ovr)        ovr_flag <= 1'b0;
        end
    end

    assert_doorbell_after_accept_R2: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_accept |=> (doorbell && busy));
    assert_doorbell_single_R2: assert property (@(posedge clk) disable iff (!rst_n)
        doorbell |=> !doorbell);
    assert_overrun_sticky_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_wr && busy) |=> ovr_flag);
    assert_busy_clear_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && fw_done) |=> !busy);
    assert_irq_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_flag && !ack_irq) |=> irq_flag);
    assert_idle_done_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && fw_done && !cmd_wr) |=> (!busy && $stable(err_flag) && $stable(err_code)));
endmodule

// File: rtl/mbx_regfile.sv
module mbx_regfile #(
    parameter int DW        = 32,
    parameter int BUF_WORDS = 4,
    localparam int IDX_W    = $clog2(BUF_WORDS)
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    cmd_accept,
    input  logic [DW-1:0]           host_wdata,
    input  logic                    sptr_we,
    input  logic                    dptr_we,
    input  logic                    wbuf_we,
    input  logic [IDX_W-1:0]        wbuf_idx,
    input  logic                    rbuf_we,
    input  logic [IDX_W-1:0]        rbuf_idx,
    input  logic [DW-1:0]           rbuf_wdata,
    output logic [DW-1:0]           cmd_q,
    output logic [DW-1:0]           sptr_q,
    output logic [DW-1:0]           dptr_q,
    output logic [BUF_WORDS*DW-1:0] wbuf_q,
    output logic [BUF_WORDS*DW-1:0] rbuf_q
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cmd_q  <= '0;
            sptr_q <= '0;
            dptr_q <= '0;
        end else begin
            if (cmd_accept) cmd_q  <= host_wdata;
            if (sptr_we)    sptr_q <= host_wdata;
            if (dptr_we)    dptr_q <= host_wdata;
        end
    end

    for (genvar k = 0; k < BUF_WORDS; k++) begin : g_word
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                wbuf_q[k*DW +: DW] <= '0;
                rbuf_q[k*DW +: DW] <= '0;
            end else begin
                if (wbuf_we && (wbuf_idx == IDX_W'(k))) wbuf_q[k*DW +: DW] <= host_wdata;
                if (rbuf_we && (rbuf_idx == IDX_W'(k))) rbuf_q[k*DW +: DW] <= rbuf_wdata;
            end
        end
    end
endmodule

// File: rtl/hostfw_mailbox.sv
module hostfw_mailbox
    import mbx_pkg::*;
#(
    parameter int DW        = 32,
    parameter int AW        = 8,
    parameter int BUF_WORDS = 4,
    parameter int CODE_W    = 8,
    localparam int IDX_W    = $clog2(BUF_WORDS),
    localparam int LEN_W    = $clog2(BUF_WORDS + 1),
    localparam int BUF_BYTES = BUF_WORDS * 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              host_wr,
    input  logic [AW-1:0]     host_addr,
    input  logic [DW-1:0]     host_wdata,
    output logic [DW-1:0]     host_rdata,
    output logic              host_irq,
    output logic              fw_doorbell,
    output logic [DW-1:0]     fw_cmd,
    output logic [7:0]        fw_code,
    output logic [3:0]        fw_sub,
    output logic [LEN_W-1:0]  fw_len_words,
    output logic [DW-1:0]     fw_sptr,
    output logic [DW-1:0]     fw_dptr,
    input  logic [IDX_W-1:0]  fw_wbuf_idx,
    output logic [DW-1:0]     fw_wbuf_data,
    input  logic              fw_rbuf_we,
    input  logic [IDX_W-1:0]  fw_rbuf_idx,
    input  logic [DW-1:0]     fw_rbuf_wdata,
    input  logic              fw_done,
    input  logic              fw_err,
    input  logic [CODE_W-1:0] fw_err_code
);
    logic                    in_wbuf, in_rbuf, hit_cmd, hit_sts, hit_sptr, hit_dptr;
    logic [IDX_W-1:0]        host_idx;
    logic                    cmd_accept, busy, err_flag, irq_flag, ovr_flag;
    logic [CODE_W-1:0]       err_code;
    logic [DW-1:0]           cmd_q;
    logic [BUF_WORDS*DW-1:0] wbuf_q, rbuf_q;
    logic [DW-1:0]           status_w;
    logic [7:0]              len_bytes, len_clamped;

    always_comb begin
        hit_cmd  = (host_addr == AW'(OFS_CMD));
        hit_sts  = (host_addr == AW'(OFS_STS));
        hit_sptr = (host_addr == AW'(OFS_SPTR));
        hit_dptr = (host_addr == AW'(OFS_DPTR));
        in_wbuf  = (host_addr >= AW'(OFS_WBUF)) && (host_addr < AW'(OFS_WBUF + BUF_BYTES));
        in_rbuf  = (host_addr >= AW'(OFS_RBUF)) && (host_addr < AW'(OFS_RBUF + BUF_BYTES));
        host_idx = host_addr[IDX_W+1:2];
    end

    mbx_ctrl_fsm #(.CODE_W(CODE_W)) u_fsm (
        .clk         (clk),
        .rst_n       (rst_n),
        .cmd_wr      (host_wr && hit_cmd),
        .ack_irq     (host_wr && hit_sts && host_wdata[STS_IRQ_BIT]),
        .ack_ovr     (host_wr && hit_sts && host_wdata[STS_OVR_BIT]),
        .irq_req     (cmd_q[CMD_IRQ_BIT]),
        .fw_done     (fw_done),
        .fw_err      (fw_err),
        .fw_err_code (fw_err_code),
        .cmd_accept  (cmd_accept),
        .doorbell    (fw_doorbell),
        .busy        (busy),
        .err_flag    (err_flag),
        .err_code    (err_code),
        .irq_flag    (irq_flag),
        .ovr_flag    (ovr_flag)
    );

    mbx_regfile #(.DW(DW), .BUF_WORDS(BUF_WORDS)) u_regs (
        .clk        (clk),
        .rst_n      (rst_n),
        .cmd_accept (cmd_accept),
        .host_wdata (host_wdata),
        .sptr_we    (host_wr && hit_sptr),
        .dptr_we    (host_wr && hit_dptr),
        .wbuf_we    (host_wr && in_wbuf),
        .wbuf_idx   (host_idx),
        .rbuf_we    (fw_rbuf_we),
        .rbuf_idx   (fw_rbuf_idx),
        .rbuf_wdata (fw_rbuf_wdata),
        .cmd_q      (cmd_q),
        .sptr_q     (fw_sptr),
        .dptr_q     (fw_dptr),
        .wbuf_q     (wbuf_q),
        .rbuf_q     (rbuf_q)
    );

    always_comb begin
        status_w                = '0;
        status_w[STS_BUSY_BIT]  = busy;
        status_w[STS_ERR_BIT]   = err_flag;
        status_w[STS_IRQ_BIT]   = irq_flag;
        status_w[STS_OVR_BIT]   = ovr_flag;
        status_w[16 +: CODE_W]  = err_code;

        host_rdata = '0;
        if (hit_cmd)       host_rdata = cmd_q;
        else if (hit_sts)  host_rdata = status_w;
        else if (hit_sptr) host_rdata = fw_sptr;
        else if (hit_dptr) host_rdata = fw_dptr;
        else if (in_wbuf)  host_rdata = wbuf_q[host_idx*DW +: DW];
        else if (in_rbuf)  host_rdata = rbuf_q[host_idx*DW +: DW];

        len_bytes    = cmd_q[23:16];
        len_clamped  = (len_bytes > 8'(BUF_BYTES)) ? 8'(BUF_BYTES) : len_bytes;
        fw_len_words = LEN_W'((len_clamped + 8'd3) >> 2);
        fw_cmd       = cmd_q;
        fw_code      = cmd_q[7:0];
        fw_sub       = cmd_q[15:12];
        fw_wbuf_data = wbuf_q[fw_wbuf_idx*DW +: DW];
        host_irq     = irq_flag;
    end

    assert_irq_matches_flag_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && fw_done && cmd_q[CMD_IRQ_BIT]) |=> host_irq);
    assert_cmd_stable_busy_R3: assert property (@(posedge clk) disable iff (!rst_n)
        busy |=> (!busy || $stable(cmd_q)));
endmodule

// File: tb/hostfw_mailbox_tb.sv
`timescale 1ns/1ps
module hostfw_mailbox_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        host_wr = 1'b0;
    logic [7:0]  host_addr = '0;
    logic [31:0] host_wdata = '0;
    logic [31:0] host_rdata;
    logic        host_irq, fw_doorbell;
    logic [31:0] fw_cmd, fw_sptr, fw_dptr, fw_wbuf_data;
    logic [7:0]  fw_code;
    logic [3:0]  fw_sub;
    logic [2:0]  fw_len_words;
    logic [1:0]  fw_wbuf_idx = '0;
    logic        fw_rbuf_we = 1'b0;
    logic [1:0]  fw_rbuf_idx = '0;
    logic [31:0] fw_rbuf_wdata = '0;
    logic        fw_done = 1'b0;
    logic        fw_err = 1'b0;
    logic [7:0]  fw_err_code = '0;

    int n_vec = 0;
    int n_bad = 0;

    always #2.5 clk = ~clk;

    hostfw_mailbox u_dut (
        .clk(clk), .rst_n(rst_n), .host_wr(host_wr), .host_addr(host_addr),
        .host_wdata(host_wdata), .host_rdata(host_rdata), .host_irq(host_irq),
        .fw_doorbell(fw_doorbell), .fw_cmd(fw_cmd), .fw_code(fw_code), .fw_sub(fw_sub),
        .fw_len_words(fw_len_words), .fw_sptr(fw_sptr), .fw_dptr(fw_dptr),
        .fw_wbuf_idx(fw_wbuf_idx), .fw_wbuf_data(fw_wbuf_data), .fw_rbuf_we(fw_rbuf_we),
        .fw_rbuf_idx(fw_rbuf_idx), .fw_rbuf_wdata(fw_rbuf_wdata), .fw_done(fw_done),
        .fw_err(fw_err), .fw_err_code(fw_err_code)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_vec++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
        end
    endtask

    task automatic hw(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        host_addr = a; host_wdata = d; host_wr = 1'b1;
        @(posedge clk); #1;
        host_wr = 1'b0;
    endtask

    task automatic hr(input logic [7:0] a, output logic [31:0] d);
        host_addr = a;
        #0.5;
        d = host_rdata;
    endtask

    task automatic fdone(input logic e, input logic [7:0] c);
        @(negedge clk);
        fw_done = 1'b1; fw_err = e; fw_err_code = c;
        @(posedge clk); #1;
        fw_done = 1'b0; fw_err = 1'b0; fw_err_code = '0;
    endtask

    task automatic fwr(input logic [1:0] k, input logic [31:0] d);
        @(negedge clk);
        fw_rbuf_we = 1'b1; fw_rbuf_idx = k; fw_rbuf_wdata = d;
        @(posedge clk); #1;
        fw_rbuf_we = 1'b0;
    endtask

    initial begin
        #(5.0 * 200000);
        n_bad++;
        $display("FAIL watchdog: actual 0x%08h expected 0x%08h", 1, 0);
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

    initial begin
        logic [31:0] rd;
        logic [31:0] exp_sts;
        repeat (3) @(posedge clk);
        #1;
        // R1 reset state
        for (int a = 0; a < 256; a += 4) begin
            hr(8'(a), rd);
            chk("R1 reset read", rd, 32'h0);
        end
        chk("R1 irq", {31'b0, host_irq}, 0);
        chk("R1 doorbell", {31'b0, fw_doorbell}, 0);
        @(negedge clk); rst_n = 1'b1;
        @(posedge clk); #1;

        // R6 completion while idle
        fdone(1'b1, 8'h05);
        hr(8'h04, rd); chk("R6 idle done status", rd, 32'h0);
        chk("R6 idle done irq", {31'b0, host_irq}, 0);

        // R9 pointers
        hw(8'h08, 32'hA5A5_0001);
        hw(8'h0C, 32'h5A5A_0002);
        hr(8'h08, rd); chk("R9 sptr read", rd, 32'hA5A5_0001);
        hr(8'h0C, rd); chk("R9 dptr read", rd, 32'h5A5A_0002);
        chk("R9 fw sptr", fw_sptr, 32'hA5A5_0001);
        chk("R9 fw dptr", fw_dptr, 32'h5A5A_0002);

        // R7 payload words, R8 response words
        for (int k = 0; k < 4; k++) begin
            hw(8'(8'h80 + 4*k), 32'h1000_0000 * (k + 1) + 32'h11 * k);
            fwr(2'(k), 32'hC0DE_0000 + 32'(k * 7));
        end
        for (int k = 0; k < 4; k++) begin
            hr(8'(8'h80 + 4*k), rd);
            chk("R7 payload host read", rd, 32'h1000_0000 * (k + 1) + 32'h11 * k);
            fw_wbuf_idx = 2'(k); #0.5;
            chk("R7 payload fw read", fw_wbuf_data, 32'h1000_0000 * (k + 1) + 32'h11 * k);
            hr(8'(8'h90 + 4*k), rd);
            chk("R8 response host read", rd, 32'hC0DE_0000 + 32'(k * 7));
        end

        // R10 undefined offsets
        hw(8'h40, 32'hFFFF_FFFF);
        hw(8'hA0, 32'hFFFF_FFFF);
        hr(8'h40, rd); chk("R10 undefined read", rd, 0);
        hr(8'hA0, rd); chk("R10 undefined read", rd, 0);
        hr(8'h10, rd); chk("R10 undefined read", rd, 0);
        hr(8'h08, rd); chk("R10 sptr untouched", rd, 32'hA5A5_0001);
        hr(8'h00, rd); chk("R10 cmd untouched", rd, 0);
        chk("R10 no doorbell", {31'b0, fw_doorbell}, 0);

        // R2 R4 R5 sweep: irq request x error flag x code
        for (int ib = 0; ib < 2; ib++) begin
            for (int e = 0; e < 2; e++) begin
                for (int c = 0; c < 8; c++) begin
                    logic [31:0] cmd;
                    cmd = (32'(c * 2) << 16) | (32'(c) << 12) | (32'(ib) << 8) | 32'(8'h20 + c);
                    hw(8'h00, cmd);
                    chk("R2 doorbell high", {31'b0, fw_doorbell}, 1);
                    hr(8'h04, rd); chk("R2 busy after write", rd, 32'h1);
                    hr(8'h00, rd); chk("R2 cmd stored", rd, cmd);
                    @(posedge clk); #1;
                    chk("R2 doorbell single cycle", {31'b0, fw_doorbell}, 0);
                    fdone(e[0], 8'(c));
                    exp_sts = (e ? (32'(c) << 16) : 0) | (32'(ib) << 2) | (32'(e) << 1);
                    hr(8'h04, rd); chk("R4 status after completion", rd, exp_sts);
                    chk("R5 irq level", {31'b0, host_irq}, 32'(ib));
                    @(posedge clk); #1;
                    chk("R5 irq holds", {31'b0, host_irq}, 32'(ib));
                    if (ib != 0) begin
                        hw(8'h04, 32'h4);
                        chk("R5 irq acked", {31'b0, host_irq}, 0);
                        hr(8'h04, rd); chk("R5 status after ack", rd, exp_sts & ~32'h4);
                    end
                end
            end
        end
        // R4 new command clears error fields
        hw(8'h00, 32'h0000_0031);
        hr(8'h04, rd); chk("R4 accept clears error", rd, 32'h1);
        // R3 write while busy
        hw(8'h00, 32'h0000_01FF);
        hr(8'h00, rd); chk("R3 cmd unchanged", rd, 32'h0000_0031);
        chk("R3 no doorbell", {31'b0, fw_doorbell}, 0);
        hr(8'h04, rd); chk("R3 overrun set", rd, 32'h9);
        fdone(1'b0, 8'h00);
        hr(8'h04, rd); chk("R3 overrun sticky", rd, 32'h8);
        chk("R5 no irq without request", {31'b0, host_irq}, 0);
        hw(8'h04, 32'h4);
        hr(8'h04, rd); chk("R3 not cleared by irq ack", rd, 32'h8);
        hw(8'h04, 32'h8);
        hr(8'h04, rd); chk("R3 overrun cleared", rd, 32'h0);

        // R11 field decode and length sweep
        for (int len = 0; len < 24; len++) begin
            int cl;
            cl = (len > 16) ? 16 : len;
            hw(8'h00, (32'(len) << 16) | (32'(len % 16) << 12) | 32'(len + 3));
            chk("R11 len words", {29'b0, fw_len_words}, 32'((cl + 3) / 4));
            chk("R11 code", {24'b0, fw_code}, 32'(len + 3));
            chk("R11 sub", {28'b0, fw_sub}, 32'(len % 16));
            fdone(1'b0, 8'h00);
        end

        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end
endmodule